// File: doc/BRIEF.md
# Polar Modulation Parameter Generator

This block takes a stream of signed quadrature samples (I and Q) at the master sample rate. It produces the two slow control values that a polar transmitter needs. The first is an amplitude word equal to the length of the I/Q vector. The second is a signed frequency-offset word, derived from how far the vector's angle turned since the previous phase update. The carrier frequency is added to that offset downstream. Each `in_valid` pulse is one master tick.

The amplitude path and the phase path each sample on their own programmable interval, counted in master ticks. Tick 0 is the first valid sample after reset. Each path uses its own iterative vectoring CORDIC, so an update on one path never waits for the other. Each output is held between its updates, and a one-cycle strobe marks every new value. The amplitude result passes through a delay line whose length is set in master ticks. This lets the amplitude path be aligned against the frequency path to get the cleanest spectrum, for example about 190 ticks at a 4 MHz master rate with 333-tick intervals.

The angle is an unsigned fraction of a full turn, so 2^PW stands for 2π. The raw phase step is the PW-bit modular difference between the new angle and the stored one. That difference is read as a two's-complement number in [-2^(PW-1), 2^(PW-1)). The frequency word is this step times an unsigned gain input. With the gain set to round(Fs / phase interval) in hertz, the offset in hertz is `freq_out / 2^PW`.

Top module: `polar_param_gen`

## Requirements
- R1: While reset is held, `amp_out` and `freq_out` are 0 and both strobes are low.
- R2: On each tick whose index modulo `amp_div` is 0, the block samples the I/Q input. The resulting `amp_out` equals round(sqrt(I²+Q²)) within ±3 LSB, including the corner I = Q = -32768, which gives 46341.
- R3: On each tick whose index modulo `ph_div` is 0, the block measures the angle atan2(Q, I) in units of 2^-16 turn. `freq_out` then equals dp × `freq_gain` within ±4 × `freq_gain`. Here dp is the angle change since the previous phase update.
- R4: dp is unwrapped in two steps: add 65536 if it is negative, then subtract 65536 if the result is at least 32768. A clockwise rotation therefore gives a negative word, and a step of +34000 units reads as -31536.
- R5: The first phase update after reset stores the angle and reports `freq_out` = 0 exactly.
- R6: Between updates both outputs hold their value. Each strobe is high for exactly one cycle, in the cycle the new value appears.
- R7: When both paths sample the same tick, the amplitude strobe follows the frequency strobe by exactly `amp_delay` ticks (0 to 255).
- R8: The two paths decimate independently. With `in_valid` high, frequency strobes come every `ph_div` cycles and amplitude strobes every `amp_div` cycles. Both intervals must be at least ITERS+2 = 18 ticks.
- R9: With `in_valid` held high, `freq_stb` rises ITERS+2 = 18 cycles after the clock edge that captured the phase sample. With `amp_delay` = 0, the amplitude from the same sample appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One master tick; I/Q sample present |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| amp_div | input | 16 | Amplitude subsampling interval in ticks |
| ph_div | input | 16 | Phase subsampling interval in ticks |
| amp_delay | input | 8 | Extra amplitude delay in ticks |
| freq_gain | input | 16 | Unsigned scale from phase step to frequency word |
| amp_out | output | 16 | Held vector magnitude, unsigned |
| amp_stb | output | 1 | One-cycle pulse on each new amplitude |
| freq_out | output | 32 | Held frequency offset word, signed |
| freq_stb | output | 1 | One-cycle pulse on each new frequency word |

## Verification
The bench targets phase steps close to half a turn, on both sides. A design that unwrapped with only one of the two steps, or compared against π with the wrong inclusivity, would report +34000 instead of -31536 for a step just past half a turn, or would lose the sign of a clockwise rotation. It also drives the most negative I and Q together. A CORDIC without enough headroom, or with a wrong pre-rotation, would overflow there or put the angle in the wrong half-plane. Further tests run the two paths with different intervals, then with a 190-tick amplitude delay over a 333-tick interval. These catch a shared or mistimed tick counter, which would move the strobes, and a delay line that wraps or reads the wrong slot, which would shift the amplitude by a tick or lose it. The first phase update after each reset must read exactly zero. A design that differenced against a stale stored angle would report a large spurious jump.

// File: rtl/polar_param_gen.sv
module polar_param_gen #(
  parameter int W     = 16,
  parameter int PW    = 16,
  parameter int ITERS = 16,
  parameter int GW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     in_i,
  input  logic signed [W-1:0]     in_q,
  input  logic [CW-1:0]           amp_div,
  input  logic [CW-1:0]           ph_div,
  input  logic [DW-1:0]           amp_delay,
  input  logic [GW-1:0]           freq_gain,
  output logic [W-1:0]            amp_out,
  output logic                    amp_stb,
  output logic signed [PW+GW-1:0] freq_out,
  output logic                    freq_stb
);
  localparam int G     = 4;
  localparam int XW    = W + 2 + G;
  localparam int ZW    = PW + 4;
  localparam int IW    = $clog2(ITERS + 1);
  localparam int DEPTH = 1 << DW;
  localparam int FW    = PW + GW;
  localparam int MW    = XW + 17;
  localparam int INVK  = 39797;
  localparam int YLIM  = 1 << (XW - ITERS + 2);
  localparam logic [ZW-1:0] ZRND = ZW'(1) << (ZW - PW - 1);

  function automatic logic [ZW-1:0] step_ang(input int i);
    logic [31:0] t;
    case (i)
      0: t = 32'h20000000;  1: t = 32'h12E4051E;  2: t = 32'h09FB385B;  3: t = 32'h051111D4;
      4: t = 32'h028B0D43;  5: t = 32'h0145D7E1;  6: t = 32'h00A2F61E;  7: t = 32'h00517C55;
      8: t = 32'h0028BE53;  9: t = 32'h00145F2F; 10: t = 32'h000A2F98; 11: t = 32'h000517CC;
      12: t = 32'h00028BE6; 13: t = 32'h000145F3; 14: t = 32'h0000A2FA; 15: t = 32'h0000517D;
      default: t = 32'h0;
    endcase
    return ZW'(t >> (32 - ZW));
  endfunction

  logic [CW-1:0] acnt, pcnt;
  logic [1:0]    start, busy, fin;
  assign start = {in_valid && pcnt == '0, in_valid && acnt == '0};

  always_ff @(posedge clk) begin
    if (rst) begin
      acnt <= '0;
      pcnt <= '0;
    end else if (in_valid) begin
      acnt <= (acnt >= amp_div - CW'(1)) ? '0 : acnt + CW'(1);
      pcnt <= (pcnt >= ph_div  - CW'(1)) ? '0 : pcnt + CW'(1);
    end
  end

  logic signed [XW-1:0] ix, iq, x0, y0;
  logic [ZW-1:0]        z0;
  assign ix = $signed({{2{in_i[W-1]}}, in_i, {G{1'b0}}});
  assign iq = $signed({{2{in_q[W-1]}}, in_q, {G{1'b0}}});
  assign x0 = in_i[W-1] ? -ix : ix;
  assign y0 = in_i[W-1] ? -iq : iq;
  assign z0 = in_i[W-1] ? {1'b1, {(ZW-1){1'b0}}} : '0;

  logic signed [XW-1:0] x [2];
  logic signed [XW-1:0] y [2];
  logic [ZW-1:0]        z [2];
  logic [IW-1:0]        it [2];

  for (genvar k = 0; k < 2; k++) begin : g_fin
    assign fin[k] = busy[k] && it[k] == IW'(ITERS);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        busy[k] <= 1'b0;
        it[k]   <= '0;
        x[k]    <= '0;
        y[k]    <= '0;
        z[k]    <= '0;
      end else if (start[k]) begin
        busy[k] <= 1'b1;
        it[k]   <= '0;
        x[k]    <= x0;
        y[k]    <= y0;
        z[k]    <= z0;
      end else if (busy[k]) begin
        if (fin[k]) begin
          busy[k] <= 1'b0;
        end else begin
          if (y[k][XW-1]) begin
            x[k] <= x[k] - (y[k] >>> it[k]);
            y[k] <= y[k] + (x[k] >>> it[k]);
            z[k] <= z[k] - step_ang(int'(it[k]));
          end else begin
            x[k] <= x[k] + (y[k] >>> it[k]);
            y[k] <= y[k] - (x[k] >>> it[k]);
            z[k] <= z[k] + step_ang(int'(it[k]));
          end
          it[k] <= it[k] + IW'(1);
        end
      end
    end
  end

  logic [W-1:0]  amp_val;
  logic [FW-1:0] frq_val;
  logic          amp_new, frq_new, ph_seen;
  logic [PW-1:0] prev_ang, ang_w, dp_w;
  assign ang_w = PW'((z[1] + ZRND) >> (ZW - PW));
  assign dp_w  = ang_w - prev_ang;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_val  <= '0;
      amp_new  <= 1'b0;
      frq_val  <= '0;
      frq_new  <= 1'b0;
      prev_ang <= '0;
      ph_seen  <= 1'b0;
    end else begin
      if (in_valid) begin
        amp_new <= 1'b0;
        frq_new <= 1'b0;
      end
      if (fin[0]) begin
        amp_val <= W'((MW'($unsigned(x[0])) * MW'(INVK) + (MW'(1) << (15 + G))) >> (16 + G));
        amp_new <= 1'b1;
      end
      if (fin[1]) begin
        frq_val  <= ph_seen ? FW'(FW'($signed(dp_w)) * FW'($signed({1'b0, freq_gain}))) : '0;
        prev_ang <= ang_w;
        ph_seen  <= 1'b1;
        frq_new  <= 1'b1;
      end
    end
  end

  logic [W-1:0]     dmem [DEPTH];
  logic [DEPTH-1:0] dflg;
  logic [DW-1:0]    wp, rd_idx;
  logic [W-1:0]     rd_v;
  logic             rd_f;
  assign rd_idx = wp - amp_delay;
  assign rd_v   = (amp_delay == '0) ? amp_val : dmem[rd_idx];
  assign rd_f   = (amp_delay == '0) ? amp_new : dflg[rd_idx];

  always_ff @(posedge clk) begin
    if (in_valid) dmem[wp] <= amp_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dflg     <= '0;
      wp       <= '0;
      amp_out  <= '0;
      amp_stb  <= 1'b0;
      freq_out <= '0;
      freq_stb <= 1'b0;
    end else begin
      amp_stb  <= in_valid && rd_f;
      freq_stb <= in_valid && frq_new;
      if (in_valid) begin
        dflg[wp] <= amp_new;
        wp       <= wp + DW'(1);
        if (rd_f)    amp_out  <= rd_v;
        if (frq_new) freq_out <= frq_val;
      end
    end
  end

  a_r6_amp_hold: assert property (@(posedge clk) disable iff (rst) !amp_stb |-> $stable(amp_out));
  a_r6_freq_hold: assert property (@(posedge clk) disable iff (rst) !freq_stb |-> $stable(freq_out));
  a_r6_freq_pulse: assert property (@(posedge clk) disable iff (rst) freq_stb |=> !freq_stb);
  a_r3_converged: assert property (@(posedge clk) disable iff (rst)
    fin[1] |-> (y[1] < YLIM) && (y[1] > -YLIM));
  a_r8_interval_ok: assert property (@(posedge clk) disable iff (rst)
    !((start[0] && busy[0]) || (start[1] && busy[1])));
endmodule

// File: tb/polar_param_gen_test.sv
`timescale 1ns/1ps
module polar_param_gen_test;
  localparam int LAT = 18;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [15:0] in_i = 0, in_q = 0;
  logic [15:0] amp_div = 40, ph_div = 40, freq_gain = 100;
  logic [7:0]  amp_delay = 0;
  logic [15:0] amp_out;
  logic signed [31:0] freq_out;
  logic amp_stb, freq_stb;

  polar_param_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .amp_div(amp_div), .ph_div(ph_div), .amp_delay(amp_delay), .freq_gain(freq_gain),
    .amp_out(amp_out), .amp_stb(amp_stb), .freq_out(freq_out), .freq_stb(freq_stb));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int k;
  real r0, rslope, ang0, astep;
  bit first_ph;
  longint last_amp, last_freq;
  string stb_tag, amp_tag, frq_tag;

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int clampi(int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  function automatic int smp_i(int j);
    return clampi(rnd((r0 + rslope * j) * $cos(TWO_PI * (ang0 + astep * j) / 65536.0)));
  endfunction

  function automatic int smp_q(int j);
    return clampi(rnd((r0 + rslope * j) * $sin(TWO_PI * (ang0 + astep * j) / 65536.0)));
  endfunction

  function automatic real ang_of(int j);
    real a;
    a = $atan2(real'(smp_q(j)), real'(smp_i(j))) * 65536.0 / TWO_PI;
    if (a < 0.0) a = a + 65536.0;
    return a;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic start_run(int ad, int pd, int dl, int g, real m0, real ms, real a0, real as_);
    rst = 1; in_valid = 0;
    amp_div = 16'(ad); ph_div = 16'(pd); amp_delay = 8'(dl); freq_gain = 16'(g);
    r0 = m0; rslope = ms; ang0 = a0; astep = as_;
    repeat (3) @(negedge clk);
    rst = 0; k = 0;
    in_i = 16'(smp_i(0)); in_q = 16'(smp_q(0)); in_valid = 1;
    first_ph = 1; last_amp = 0; last_freq = 0;
  endtask

  task automatic step();
    int jf, ja, expa;
    bit ef, ea;
    real dp;
    longint expf, diff;
    @(negedge clk);
    jf = k - LAT;
    ja = k - LAT - int'(amp_delay);
    ef = (jf >= 0) && (jf % int'(ph_div) == 0);
    ea = (ja >= 0) && (ja % int'(amp_div) == 0);
    check(freq_stb == ef, stb_tag, "freq strobe", longint'(freq_stb), longint'(ef));
    if (ef && freq_stb) begin
      if (first_ph) begin
        check(freq_out == 0, "R5", "first freq", longint'(freq_out), 0);
        first_ph = 0;
      end else begin
        dp = ang_of(jf) - ang_of(jf - int'(ph_div));
        if (dp < 0.0) dp = dp + 65536.0;
        if (dp >= 32768.0) dp = dp - 65536.0;
        expf = longint'(rnd(dp * real'(freq_gain)));
        diff = longint'(freq_out) - expf;
        check(diff <= 4 * longint'(freq_gain) && diff >= -4 * longint'(freq_gain),
              frq_tag, "freq value", longint'(freq_out), expf);
      end
    end else if (!freq_stb) begin
      check(longint'(freq_out) == last_freq, "R6", "freq hold", longint'(freq_out), last_freq);
    end
    last_freq = longint'(freq_out);
    check(amp_stb == ea, stb_tag, "amp strobe", longint'(amp_stb), longint'(ea));
    if (ea && amp_stb) begin
      expa = rnd($sqrt(real'(smp_i(ja)) ** 2 + real'(smp_q(ja)) ** 2));
      diff = longint'(amp_out) - longint'(expa);
      check(diff <= 3 && diff >= -3, amp_tag, "amp value", longint'(amp_out), longint'(expa));
    end else if (!amp_stb) begin
      check(longint'(amp_out) == last_amp, "R6", "amp hold", longint'(amp_out), last_amp);
    end
    last_amp = longint'(amp_out);
    k++;
    in_i = 16'(smp_i(k)); in_q = 16'(smp_q(k));
  endtask

  task automatic t_reset();
    rst = 1; in_valid = 1; in_i = 16'sd1234; in_q = -16'sd999;
    repeat (5) @(negedge clk);
    check(amp_out == 0, "R1", "amp in reset", longint'(amp_out), 0);
    check(freq_out == 0, "R1", "freq in reset", longint'(freq_out), 0);
    check(amp_stb == 0, "R1", "amp_stb in reset", longint'(amp_stb), 0);
    check(freq_stb == 0, "R1", "freq_stb in reset", longint'(freq_stb), 0);
  endtask

  task automatic t_static();
    stb_tag = "R9"; amp_tag = "R2"; frq_tag = "R3";
    start_run(40, 40, 0, 100, 5000.0, 0.0, 8000.0, 0.0);
    repeat (200) step();
  endtask

  task automatic t_corner();
    stb_tag = "R9"; amp_tag = "R2"; frq_tag = "R3";
    start_run(40, 40, 0, 100, 32768.0 * 1.4142135623730951, 0.0, 40960.0, 0.0);
    repeat (150) step();
  endtask

  task automatic t_spin(real per_tick, string tag);
    stb_tag = "R9"; amp_tag = "R2"; frq_tag = tag;
    start_run(40, 40, 0, 100, 20000.0, 0.0, 1000.0, per_tick);
    repeat (300) step();
  endtask

  task automatic t_indep();
    stb_tag = "R8"; amp_tag = "R2"; frq_tag = "R3";
    start_run(50, 70, 0, 100, 1000.0, 15.0, 500.0, 20.0);
    repeat (800) step();
  endtask

  task automatic t_delay(int dv, int dl, int steps);
    stb_tag = "R7"; amp_tag = "R2"; frq_tag = "R3";
    start_run(dv, dv, dl, 12, 3000.0, 8.0, 200.0, 10.0);
    repeat (steps) step();
  endtask

  initial begin
    t_reset();
    t_static();
    t_corner();
    t_spin(75.0, "R3");
    t_spin(-125.0, "R4");
    t_spin(850.0, "R4");
    t_spin(750.0, "R4");
    t_indep();
    t_delay(333, 190, 1400);
    t_delay(40, 7, 300);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule